// File: doc/BRIEF.md
# Raster Sync and Blanking Timing Generator

This block produces the line and frame timing for a reduced-resolution raster display running on a 12 MHz pixel clock. A pixel counter advances on every clock. A line counter advances once each time the pixel counter completes a line. Both counts are brought out so that a later fetch stage can form memory addresses from them.

From the two counts the block drives an active-low horizontal sync and an active-low vertical sync, each inside a fixed window of count values. Each sync edge lands one clock after its trigger count, which leaves room for a two-stage pixel pipeline downstream. The block also drives a combinational blanking flag that is true outside the 256 × 480 visible area. A registered copy of that flag lines up with a colour stage one clock later.

All sizes, totals and sync windows are parameters. With the default values a line is 381 clocks (31.75 µs) and a frame is 528 lines.

Top module: `vsg_timing_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `pix_cnt`=0, `line_cnt`=0, `hsync_n`=1, `vsync_n`=1 and `blank_q`=1.
- R2: Outside reset, `pix_cnt` increases by one per clock from 0 to H_TOTAL-1 (380) and then returns to 0.
- R3: `line_cnt` changes only on the clock where `pix_cnt` wraps from H_TOTAL-1 to 0. It then increases by one, and it returns to 0 after V_TOTAL-1 (527).
- R4: `hsync_n` is 0 exactly while `pix_cnt` is in 292..337. It falls on the clock after the count 291 and rises on the clock after the count 337, so the pulse is 46 clocks long.
- R5: `vsync_n` can change only on the clock where `pix_cnt` wraps. It is 0 for the whole of lines 494 and 495, a 2-line pulse, and 1 on every other line.
- R6: `blank` is 1 exactly when `pix_cnt` ≥ 256 or `line_cnt` ≥ 480. It therefore first goes high at pixel 256 and at line 480.
- R7: `blank_q` equals the value `blank` had one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low, registered |
| vsync_n | output | 1 | Vertical sync, active low, registered |
| blank | output | 1 | Combinational blanking flag for the current counts |
| blank_q | output | 1 | Blanking flag delayed by one clock |
| pix_cnt | output | PIX_W (9) | Pixel position within the line |
| line_cnt | output | LINE_W (10) | Line position within the frame |

## Verification
The bound checker enforces the following on every clock:
- the one-step advance of the pixel counter;
- the rule that the line count and vertical sync move only at a line wrap;
- the horizontal sync edges that follow counts 291 and 337;
- the one-clock lag of the registered blanking flag.

The bench's directed scenarios show the whole-window properties that a single-step property cannot see:
- the 46-clock width of the horizontal pulse;
- the exact lines on which vertical sync is low;
- the first pixel and the first line at which blanking rises;
- the frame wrap.

To keep the run short, the bench scales the vertical parameters down, with the same relationships among them.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  // Default timing for the 12 MHz, 256 x 480 raster
  localparam int unsigned DEF_PIX_W   = 9;
  localparam int unsigned DEF_LINE_W  = 10;
  localparam int unsigned DEF_H_TOTAL = 381;
  localparam int unsigned DEF_H_VIS   = 256;
  localparam int unsigned DEF_HS_ON   = 291;
  localparam int unsigned DEF_HS_OFF  = 337;
  localparam int unsigned DEF_V_TOTAL = 528;
  localparam int unsigned DEF_V_VIS   = 480;
  localparam int unsigned DEF_VS_ON   = 493;
  localparam int unsigned DEF_VS_OFF  = 495;
endpackage

// File: rtl/vsg_wrap_counter.sv
module vsg_wrap_counter #(
  parameter int unsigned W     = 9,
  parameter int unsigned LIMIT = 381
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         last
);
  localparam logic [W-1:0] LAST_V = W'(LIMIT - 1);

  assign last = (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (en)
      cnt <= last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/vsg_sync_pulse.sv
module vsg_sync_pulse #(
  parameter int unsigned W   = 9,
  parameter int unsigned ON  = 291,
  parameter int unsigned OFF = 337
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] pos,
  output logic         sync_n
);
  localparam logic [W-1:0] ON_V  = W'(ON);
  localparam logic [W-1:0] OFF_V = W'(OFF);

  // Edges appear one clock after the trigger count
  always_ff @(posedge clk) begin
    if (rst)
      sync_n <= 1'b1;
    else if (en) begin
      if (pos == ON_V)
        sync_n <= 1'b0;
      else if (pos == OFF_V)
        sync_n <= 1'b1;
    end
  end
endmodule

// File: rtl/vsg_blank_gen.sv
module vsg_blank_gen #(
  parameter int unsigned PIX_W  = 9,
  parameter int unsigned LINE_W = 10,
  parameter int unsigned H_VIS  = 256,
  parameter int unsigned V_VIS  = 480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  output logic              blank,
  output logic              blank_q
);
  localparam logic [PIX_W-1:0]  HV = PIX_W'(H_VIS);
  localparam logic [LINE_W-1:0] VV = LINE_W'(V_VIS);

  assign blank = (pix >= HV) || (line >= VV);

  always_ff @(posedge clk) begin
    if (rst)
      blank_q <= 1'b1;
    else
      blank_q <= blank;
  end
endmodule

// File: rtl/vsg_timing_gen.sv
module vsg_timing_gen
  import vsg_pkg::*;
#(
  parameter int unsigned PIX_W   = DEF_PIX_W,
  parameter int unsigned LINE_W  = DEF_LINE_W,
  parameter int unsigned H_TOTAL = DEF_H_TOTAL,
  parameter int unsigned H_VIS   = DEF_H_VIS,
  parameter int unsigned HS_ON   = DEF_HS_ON,
  parameter int unsigned HS_OFF  = DEF_HS_OFF,
  parameter int unsigned V_TOTAL = DEF_V_TOTAL,
  parameter int unsigned V_VIS   = DEF_V_VIS,
  parameter int unsigned VS_ON   = DEF_VS_ON,
  parameter int unsigned VS_OFF  = DEF_VS_OFF
) (
  input  logic              clk,
  input  logic              rst,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              blank,
  output logic              blank_q,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt
);
  logic line_end;
  logic frame_end;

  vsg_wrap_counter #(.W(PIX_W), .LIMIT(H_TOTAL)) u_pix (
    .clk(clk), .rst(rst), .en(1'b1), .cnt(pix_cnt), .last(line_end)
  );

  vsg_wrap_counter #(.W(LINE_W), .LIMIT(V_TOTAL)) u_line (
    .clk(clk), .rst(rst), .en(line_end), .cnt(line_cnt), .last(frame_end)
  );

  vsg_sync_pulse #(.W(PIX_W), .ON(HS_ON), .OFF(HS_OFF)) u_hs (
    .clk(clk), .rst(rst), .en(1'b1), .pos(pix_cnt), .sync_n(hsync_n)
  );

  // Vertical sync is evaluated only as a line completes
  vsg_sync_pulse #(.W(LINE_W), .ON(VS_ON), .OFF(VS_OFF)) u_vs (
    .clk(clk), .rst(rst), .en(line_end), .pos(line_cnt), .sync_n(vsync_n)
  );

  vsg_blank_gen #(.PIX_W(PIX_W), .LINE_W(LINE_W), .H_VIS(H_VIS), .V_VIS(V_VIS)) u_blank (
    .clk(clk), .rst(rst), .pix(pix_cnt), .line(line_cnt),
    .blank(blank), .blank_q(blank_q)
  );

  logic unused_frame_end;
  assign unused_frame_end = frame_end;
endmodule

// File: rtl/vsg_timing_chk.sv
module vsg_timing_chk #(
  parameter int unsigned PIX_W   = 9,
  parameter int unsigned LINE_W  = 10,
  parameter int unsigned H_TOTAL = 381,
  parameter int unsigned HS_ON   = 291,
  parameter int unsigned HS_OFF  = 337
) (
  input logic              clk,
  input logic              rst,
  input logic              hsync_n,
  input logic              vsync_n,
  input logic              blank,
  input logic              blank_q,
  input logic [PIX_W-1:0]  pix_cnt,
  input logic [LINE_W-1:0] line_cnt
);
  localparam logic [PIX_W-1:0] P_LAST = PIX_W'(H_TOTAL - 1);
  localparam logic [PIX_W-1:0] P_ON   = PIX_W'(HS_ON);
  localparam logic [PIX_W-1:0] P_OFF  = PIX_W'(HS_OFF);

  // R2
  a_r2_pix_step: assert property (@(posedge clk) disable iff (rst)
    (pix_cnt != P_LAST) |=> (pix_cnt == $past(pix_cnt) + 1'b1));
  // R2
  a_r2_pix_wrap: assert property (@(posedge clk) disable iff (rst)
    (pix_cnt == P_LAST) |=> (pix_cnt == '0));
  // R3
  a_r3_line_hold: assert property (@(posedge clk) disable iff (rst)
    (pix_cnt != P_LAST) |=> $stable(line_cnt));
  // R4
  a_r4_hs_fall: assert property (@(posedge clk) disable iff (rst)
    (pix_cnt == P_ON) |=> !hsync_n);
  // R4
  a_r4_hs_rise: assert property (@(posedge clk) disable iff (rst)
    (pix_cnt == P_OFF) |=> hsync_n);
  // R5
  a_r5_vs_at_wrap_only: assert property (@(posedge clk) disable iff (rst)
    (pix_cnt != P_LAST) |=> $stable(vsync_n));
  // R7
  a_r7_blank_lag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (blank_q == $past(blank)));
endmodule

bind vsg_timing_gen vsg_timing_chk #(
  .PIX_W(PIX_W), .LINE_W(LINE_W), .H_TOTAL(H_TOTAL), .HS_ON(HS_ON), .HS_OFF(HS_OFF)
) u_chk (
  .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank),
  .blank_q(blank_q), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
);

// File: tb/vsg_timing_gen_tb.sv
module vsg_timing_gen_tb;
  localparam int HT = 381;
  localparam int VT = 40;
  localparam int VV = 30;
  localparam int VON = 33;
  localparam int VOFF = 35;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_n, vsync_n, blank, blank_q;
  logic [8:0] pix_cnt;
  logic [9:0] line_cnt;
  int n_chk = 0;
  int n_fail = 0;
  int k = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vsg_timing_gen #(.V_TOTAL(VT), .V_VIS(VV), .VS_ON(VON), .VS_OFF(VOFF)) u_dut (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank),
    .blank_q(blank_q), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  // Count of clocks since reset was released
  always @(posedge clk) begin
    if (rst) k <= 0;
    else k <= k + 1;
  end

  function automatic int e_pix(int c);  return c % HT; endfunction
  function automatic int e_line(int c); return (c / HT) % VT; endfunction
  function automatic bit e_blank(int c);
    return (e_pix(c) >= 256) || (e_line(c) >= VV);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (k=%0d)", req, act, exp, k);
    end
  endtask

  task automatic go_to(int target);
    while (k != target) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pix", pix_cnt, 0);
    chk("R1 line", line_cnt, 0);
    chk("R1 hsync_n", hsync_n, 1);
    chk("R1 vsync_n", vsync_n, 1);
    chk("R1 blank_q", blank_q, 1);
    rst = 1'b0;
  endtask

  task automatic t_first_line();
    for (int c = 0; c <= HT; c++) begin
      go_to(c);
      chk("R2 pix", pix_cnt, e_pix(c));
      chk("R3 line", line_cnt, e_line(c));
    end
  endtask

  task automatic t_hsync();
    int lows = 0;
    for (int c = HT; c < 2 * HT; c++) begin
      go_to(c);
      chk("R4 hsync_n", hsync_n, (e_pix(c) >= 292 && e_pix(c) <= 337) ? 0 : 1);
      if (!hsync_n) lows++;
    end
    chk("R4 width", lows, 46);
  endtask

  task automatic t_blank();
    go_to(2 * HT + 255);
    chk("R6 blank@255", blank, 0);
    chk("R7 blank_q@255", blank_q, 0);
    go_to(2 * HT + 256);
    chk("R6 blank@256", blank, 1);
    chk("R7 blank_q@256", blank_q, 0);
    go_to(2 * HT + 257);
    chk("R7 blank_q@257", blank_q, 1);
    go_to(3 * HT);
    chk("R6 blank line3 start", blank, 0);
    chk("R7 blank_q line3 start", blank_q, 1);
    go_to((VV - 1) * HT + 100);
    chk("R6 blank last visible line", blank, 0);
    go_to(VV * HT);
    chk("R6 blank first blank line", blank, e_blank(VV * HT) ? 1 : 0);
    chk("R6 blank line start", blank, 1);
    go_to(VV * HT + 1);
    chk("R7 blank_q line start", blank_q, 1);
  endtask

  task automatic t_vsync();
    for (int l = VON - 1; l <= VOFF + 2; l++) begin
      go_to(l * HT);
      chk("R5 vsync_n start", vsync_n, (l >= VON + 1 && l <= VOFF) ? 0 : 1);
      go_to(l * HT + 190);
      chk("R5 vsync_n mid", vsync_n, (l >= VON + 1 && l <= VOFF) ? 0 : 1);
      go_to(l * HT + HT - 1);
      chk("R5 vsync_n end", vsync_n, (l >= VON + 1 && l <= VOFF) ? 0 : 1);
    end
  endtask

  task automatic t_wrap();
    go_to(VT * HT - 1);
    chk("R3 last line", line_cnt, VT - 1);
    go_to(VT * HT);
    chk("R3 frame wrap line", line_cnt, 0);
    chk("R2 frame wrap pix", pix_cnt, 0);
    chk("R6 blank new frame", blank, 0);
  endtask

  task automatic t_midrun_reset();
    go_to(VT * HT + 300);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 pix mid", pix_cnt, 0);
    chk("R1 hsync_n mid", hsync_n, 1);
    chk("R1 blank_q mid", blank_q, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 pix after reset", pix_cnt, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_first_line();
    t_hsync();
    t_blank();
    t_vsync();
    t_wrap();
    t_midrun_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(190000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule